// File: doc/BRIEF.md
# Pipelined GF(2^m) Inverse-Shift Partial Multiplier

This block computes the lower-half partial product of a Montgomery-style multiplication over the binary field GF(2^m), for odd m. It takes an operand A, the low half of a second operand B, and the middle coefficients of the field polynomial G. It returns D = A · (b_0·x^-h + b_1·x^-(h-1) + ... + b_(h-1)·x^-1) mod G, where h = (m-1)/2. The block does not produce the upper-half partial product or the final sum of the two halves. Those are produced elsewhere in the datapath.

The work is a Horner evaluation, least significant B bit first. A row of m identical bit cells forms one step of the recurrence. Each step multiplies the running value by x^-1 and then adds A when the current B bit is one. Multiplying by x^-1 is a right shift by one bit. When the bit shifted out is one, the feedback weights g(1..m) are XORed back into the value, and g(m) is always one. There are (m+1)/2 rows, separated by pipeline registers. The last row sees a B bit of zero, so it applies only the final x^-1 step. A, the feedback weights and the unused B bits travel down the pipeline with the data. Each row therefore reads its own B bit one cycle after the row above, which skews B in time. A new operand set can be accepted on every clock.

An upstream controller raises `in_valid` with the operands. The downstream logic takes `d_out` in the cycles where `out_valid` is high.

Top module: `gf2m_invshift_array`

## Requirements
- R1: For an accepted operand set, `d_out` equals the Horner recurrence. Start with d = 0. For row index r = 0..h (h = (M-1)/2), the next value bit j is d[j+1] XOR (d[0] AND w[j]) XOR (c_r AND a[j]). Here d[M] = 0, c_r = `b_lo[r]` for r < h, and c_h = 0.
- R2: The result of an operand set sampled with `in_valid` high at a rising edge appears at `d_out` with `out_valid` high exactly L = (M+1)/2 + 1 rising edges later.
- R3: One operand set is accepted per clock with no stall. Results leave in the order their operands were accepted. A cycle with `in_valid` low produces a cycle with `out_valid` low at the same distance.
- R4: While `rst_n` is low, and until the first accepted operands reach the output, `out_valid` is 0. During reset `d_out` is 0.
- R5: If A is zero, or all bits of `b_lo` are zero, then D is zero.
- R6: With A = 1 and only `b_lo[k]` set, D equals x^-(h-k) mod G, i.e. the constant 1 passed through h-k inverse shifts.
- R7: The feedback weight vector is w = {1, `g_mid`}. Bit j of w, for j = 0..M-2, is `g_mid[j+1]`, the coefficient of x^(j+1) in G. The x^M coefficient is fixed at one. After a step whose shifted-out bit is one and that adds no A bit at the top, the top result bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `a_in`, `b_lo` and `g_mid` are to be accepted at this edge |
| a_in | input | M | Operand A, bit j is the coefficient of x^j |
| b_lo | input | (M-1)/2 | Low half of operand B, bit k is b_k |
| g_mid | input | M-1 (indices M-1:1) | Coefficients g(1)..g(M-1) of the field polynomial |
| out_valid | output | 1 | `d_out` carries a result |
| d_out | output | M | Partial result D, bit j is the coefficient of x^j |

## Verification
Each result is due L = (M+1)/2 + 1 rising edges after its operands are sampled, which is 9 edges for the default M = 15. The bench drives inputs on falling edges. For every driven slot it pushes the expected valid flag and value into a queue. On each later falling edge it pops the entry that is exactly L slots old and compares it against `out_valid` and `d_out`. A wrong latency, a dropped slot or a reordering therefore shows up as a mismatch in that same slot. The expected D is computed as a sum of separately inverse-shifted copies of A, one copy per set B bit. This is checked with a three-term and a five-term polynomial, with random polynomials, and with bubbles in the input stream.

// File: rtl/gf2m_invshift_pkg.sv
package gf2m_invshift_pkg;

    // number of B bits consumed by the array (the low half of B)
    function automatic int unsigned low_bits(int unsigned m);
        return (m - 1) / 2;
    endfunction

    // number of cell rows: one per low B bit plus the final reduction row
    function automatic int unsigned row_count(int unsigned m);
        return (m + 1) / 2;
    endfunction

    // width of an occupancy counter able to hold 0..n
    function automatic int unsigned count_width(int unsigned n);
        return $clog2(n + 1) + 1;
    endfunction

endpackage

// File: rtl/gf2m_invshift_cell.sv
// One bit cell: carries the upper neighbour, applies the reduction
// feedback when selected, and adds one partial-product bit.
module gf2m_invshift_cell (
    input  logic up_i,
    input  logic sel_i,
    input  logic w_i,
    input  logic b_i,
    input  logic a_i,
    output logic d_o
);
    logic fb_term;
    logic pp_term;

    always_comb begin
        fb_term = sel_i & w_i;
        pp_term = b_i & a_i;
        d_o     = up_i ^ fb_term ^ pp_term;
    end
endmodule

// File: rtl/gf2m_invshift_row.sv
// One pipeline row: M cells followed by the row register. A, the
// feedback weights and B travel alongside the partial result.
module gf2m_invshift_row
    import gf2m_invshift_pkg::*;
#(
    parameter int unsigned M       = 15,
    parameter int unsigned ROW_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [M-1:0]             a_i,
    input  logic [M-1:0]             w_i,
    input  logic [low_bits(M)-1:0]   b_i,
    input  logic [M-1:0]             d_i,
    output logic                     vld_q,
    output logic [M-1:0]             a_q,
    output logic [M-1:0]             w_q,
    output logic [low_bits(M)-1:0]   b_q,
    output logic [M-1:0]             d_q
);
    localparam int unsigned HW = low_bits(M);

    logic         b_bit;
    logic [M-1:0] d_nxt;

    // accumulating rows pick their own B bit; the final row adds nothing
    generate
        if (ROW_IDX < HW) begin : g_acc
            assign b_bit = b_i[ROW_IDX];
        end else begin : g_red
            assign b_bit = 1'b0;
        end
    endgenerate

    generate
        for (genvar j = 0; j < M; j++) begin : g_col
            logic up;
            if (j == M - 1) begin : g_top
                assign up = 1'b0;
            end else begin : g_mid
                assign up = d_i[j+1];
            end
            gf2m_invshift_cell u_cell (
                .up_i  (up),
                .sel_i (d_i[0]),
                .w_i   (w_i[j]),
                .b_i   (b_bit),
                .a_i   (a_i[j]),
                .d_o   (d_nxt[j])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            a_q   <= '0;
            w_q   <= '0;
            b_q   <= '0;
            d_q   <= '0;
        end else begin
            vld_q <= vld_i;
            a_q   <= a_i;
            w_q   <= w_i;
            b_q   <= b_i;
            d_q   <= d_nxt;
        end
    end

    // R1
    shift_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !b_bit && !d_i[0]) |=> (d_q == ($past(d_i) >> 1)));

    // R5
    zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (a_i == '0) && (d_i == '0)) |=> (d_q == '0));

    // R7
    top_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && d_i[0] && !(b_bit && a_i[M-1])) |=> d_q[M-1]);

endmodule

// File: rtl/gf2m_invshift_array.sv
module gf2m_invshift_array
    import gf2m_invshift_pkg::*;
#(
    parameter int unsigned M = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [M-1:0]             a_in,
    input  logic [low_bits(M)-1:0]   b_lo,
    input  logic [M-1:1]             g_mid,
    output logic                     out_valid,
    output logic [M-1:0]             d_out
);
    localparam int unsigned HW   = low_bits(M);
    localparam int unsigned ROWS = row_count(M);
    localparam int unsigned LAT  = ROWS + 1;
    localparam int unsigned CW   = count_width(LAT);

    // input register (stage 0)
    logic          in_v_q;
    logic [M-1:0]  in_a_q;
    logic [M-1:0]  in_w_q;
    logic [HW-1:0] in_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_v_q <= 1'b0;
            in_a_q <= '0;
            in_w_q <= '0;
            in_b_q <= '0;
        end else begin
            in_v_q <= in_valid;
            in_a_q <= a_in;
            in_w_q <= {1'b1, g_mid};
            in_b_q <= b_lo;
        end
    end

    // stage buses between rows
    logic          v_s [0:ROWS];
    logic [M-1:0]  a_s [0:ROWS];
    logic [M-1:0]  w_s [0:ROWS];
    logic [HW-1:0] b_s [0:ROWS];
    logic [M-1:0]  d_s [0:ROWS];

    assign v_s[0] = in_v_q;
    assign a_s[0] = in_a_q;
    assign w_s[0] = in_w_q;
    assign b_s[0] = in_b_q;
    assign d_s[0] = '0;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            gf2m_invshift_row #(
                .M       (M),
                .ROW_IDX (r)
            ) u_row (
                .clk   (clk),
                .rst_n (rst_n),
                .vld_i (v_s[r]),
                .a_i   (a_s[r]),
                .w_i   (w_s[r]),
                .b_i   (b_s[r]),
                .d_i   (d_s[r]),
                .vld_q (v_s[r+1]),
                .a_q   (a_s[r+1]),
                .w_q   (w_s[r+1]),
                .b_q   (b_s[r+1]),
                .d_q   (d_s[r+1])
            );
        end
    endgenerate

    assign out_valid = v_s[ROWS];
    assign d_out     = d_s[ROWS];

    // occupancy tracker for the latency checks
    logic [CW-1:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(LAT));

    // R3
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

endmodule

// File: tb/gf2m_invshift_array_tb_top.sv
`timescale 1ns/1ps
module gf2m_invshift_array_tb_top;
    localparam int unsigned M   = 15;
    localparam int unsigned HW  = (M - 1) / 2;
    localparam int unsigned LAT = (M + 1) / 2 + 1;

    localparam logic [M-1:1] TRI   = 14'h0001;   // x^15 + x + 1
    localparam logic [M-1:1] PENTA = 14'h001A;   // x^15 + x^5 + x^4 + x^2 + 1

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [M-1:0]  a_in;
    logic [HW-1:0] b_lo;
    logic [M-1:1]  g_mid;
    logic          out_valid;
    logic [M-1:0]  d_out;

    always #2.5 clk = ~clk;

    gf2m_invshift_array #(.M(M)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_lo      (b_lo),
        .g_mid     (g_mid),
        .out_valid (out_valid),
        .d_out     (d_out)
    );

    int checks = 0;
    int fails  = 0;

    bit           qv [$];
    logic [M-1:0] qd [$];
    string        qs [$];

    // multiply by x^-1 modulo G
    function automatic logic [M-1:0] inv_x(logic [M-1:0] v, logic [M-1:1] gm);
        logic [M-1:0] w;
        w = {1'b1, gm};
        return (v >> 1) ^ (v[0] ? w : '0);
    endfunction

    // D as a sum of separately shifted copies of A
    function automatic logic [M-1:0] ref_d(logic [M-1:0] a, logic [HW-1:0] b,
                                           logic [M-1:1] gm);
        logic [M-1:0] acc;
        logic [M-1:0] t;
        acc = '0;
        for (int k = 0; k < HW; k++) begin
            if (b[k]) begin
                t = a;
                for (int s = 0; s < HW - k; s++) t = inv_x(t, gm);
                acc ^= t;
            end
        end
        return acc;
    endfunction

    task automatic compare();
        bit           ev;
        logic [M-1:0] ed;
        string        es;
        if (qv.size() == LAT) begin
            ev = qv.pop_front();
            ed = qd.pop_front();
            es = qs.pop_front();
            checks++;
            if (out_valid !== ev) begin
                fails++;
                $display("FAIL R2 (%s): out_valid=%0b expected %0b", es, out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (d_out !== ed) begin
                    fails++;
                    $display("FAIL %s: d_out=%h expected %h", es, d_out, ed);
                end
            end
        end else begin
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R4 pipeline fill: out_valid=%0b expected 0", out_valid);
            end
        end
    endtask

    task automatic step(bit v, logic [M-1:0] a, logic [HW-1:0] b,
                        logic [M-1:1] gm, string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        a_in     = a;
        b_lo     = b;
        g_mid    = gm;
        qv.push_back(v);
        qd.push_back(v ? ref_d(a, b, gm) : '0);
        qs.push_back(tag);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        a_in     = '0;
        b_lo     = '0;
        g_mid    = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || d_out !== '0) begin
            fails++;
            $display("FAIL R4 reset: out_valid=%0b d_out=%h expected 0 and 0", out_valid, d_out);
        end
        rst_n = 1'b1;

        // R6: single B bit with A = 1
        for (int k = 0; k < HW; k++) step(1'b1, M'(1), HW'(1) << k, TRI,   "R6 single bit trinomial");
        for (int k = 0; k < HW; k++) step(1'b1, M'(1), HW'(1) << k, PENTA, "R6 single bit pentanomial");

        // R5: zero operands
        step(1'b1, '0, HW'($urandom), PENTA, "R5 zero A");
        step(1'b1, M'($urandom), '0, TRI, "R5 zero B");
        step(1'b1, '0, '0, '1, "R5 both zero");

        // R7: extreme feedback weights
        step(1'b1, '1, '1, '0, "R7 top-only feedback");
        step(1'b1, '1, '1, '1, "R7 all-ones feedback");
        step(1'b1, M'(1) << (M - 1), HW'(1), '0, "R7 top bit A");

        // R1: back-to-back random operands
        for (int n = 0; n < 200; n++) begin
            logic [M-1:1] gsel;
            gsel = (n % 3 == 0) ? TRI : (n % 3 == 1) ? PENTA : (M-1)'($urandom);
            step(1'b1, M'($urandom), HW'($urandom), gsel, "R1 random stream");
        end

        // R3: random bubbles
        for (int n = 0; n < 200; n++) begin
            step(($urandom % 4) != 0, M'($urandom), HW'($urandom),
                 (n % 2 == 0) ? PENTA : TRI, "R3 stream with bubbles");
        end

        // R3: drain
        for (int n = 0; n < LAT + 1; n++) step(1'b0, '0, '0, '0, "R3 drain");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: run did not finish, actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule